// File: doc/BRIEF.md
# Single-Pass Lookahead Adder for Residues Modulo 2^W+1

This block adds two residues modulo 2^W+1 and returns the sum as a residue, in one pass through one W-bit carry-lookahead network. Each residue is carried as a W-bit field plus a one-bit non-zero flag. The flag is low only for the value zero, and it then requires the field to be all zeros. A non-zero value V (1 to 2^W) is sent as field V-1 with the flag high. This lets the whole range 0 to 2^W fit in W+1 bits, and a plain binary adder core can serve the modulus.

The lookahead first works out whether the two fields overflow W bits with no carry-in. From that it sets the real carry-in: high only when both operands are non-zero and that overflow is absent. The corrected carry-in is folded into every carry equation as one more product term, so there is no second adder and no second pass. The result flag comes from the same overflow and the final carry-out. A parameter adds an optional output register with one cycle of latency. The adder suits residue number datapaths and arithmetic error-checking channels that need this modulus next to the 2^W and 2^W-1 channels.

Top module: `mod2n1_cla_adder`

## Requirements
- R1: An operand is the pair (field, flag). Flag 0 means the value zero, and the field must then be 0. Flag 1 means the value field+1, in the range 1 to 2^W.
- R2: For every pair of valid operands, the output pair encodes (A+B) mod (2^W+1) in the encoding of R1.
- R3: The output flag is 0 exactly when the modular sum is zero, and the output field is then all zeros.
- R4: When one operand has flag 0, the output pair equals the other operand's pair.
- R5: When both flags are 1 and field_a + field_b = 2^W-1, the output is zero (flag 0, field 0).
- R6: When both flags are 1 and field_a + field_b >= 2^W, the output flag is 1 and the output field is field_a + field_b - 2^W.
- R7: When both flags are 1 and field_a + field_b <= 2^W-2, the output flag is 1 and the output field is field_a + field_b + 1.
- R8: With OUT_MODE = OUT_COMB the output follows the inputs with no clock. With OUT_MODE = OUT_REG the output shows the result of the inputs sampled at the previous rising clock edge and holds it until the next edge: a latency of exactly one cycle.
- R9: With OUT_MODE = OUT_REG, while rst_n is low the output pair is (0, 0) whatever the inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register and the checks |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| a_val | input | W | Field of operand A |
| a_nz | input | 1 | Non-zero flag of operand A |
| b_val | input | W | Field of operand B |
| b_nz | input | 1 | Non-zero flag of operand B |
| sum_val | output | W | Field of the modular sum |
| sum_nz | output | 1 | Non-zero flag of the modular sum |

## Verification
The bench targets the boundary where the two fields sum to exactly 2^W-1. There the corrected carry-in ripples all the way out. A design that used the wrong carry-out for the flag would report 2^W instead of zero, or would leave a stale field behind a cleared flag. It also drives operands that overflow W bits. A design that applied the carry-in regardless of overflow would come out one too high there, and one that dropped it in the non-overflow range would come out one too low. Zero operands and the largest value 2^W go in on both sides, along with a check that the registered output holds its old value until the clock edge. For a narrow width the bench runs every pair of operands.

// File: rtl/mod2n1_pkg.sv
package mod2n1_pkg;

  // Selects whether the result leaves through a register stage.
  typedef enum logic {
    OUT_COMB = 1'b0,
    OUT_REG  = 1'b1
  } out_mode_e;

endpackage

// File: rtl/mod2n1_pg.sv
// Per-bit generate and propagate terms of the two operand fields.
module mod2n1_pg #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] gen,
  output logic [W-1:0] prop
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign gen[i]  = a[i] & b[i];
    assign prop[i] = a[i] ^ b[i];
  end

endmodule

// File: rtl/mod2n1_lookahead.sv
// Flat carry-lookahead with the modular carry-in folded into each carry.
// carry[i] is the carry into bit i; carry[0] is the corrected carry-in,
// carry[W] the final carry-out.
module mod2n1_lookahead #(
  parameter int W = 16
) (
  input  logic [W-1:0] gen,
  input  logic [W-1:0] prop,
  input  logic         a_nz,
  input  logic         b_nz,
  output logic         ovf0,
  output logic [W:0]   carry
);

  localparam logic [W:0] UNIT = {{W{1'b0}}, 1'b1};

  logic         hot;
  logic         cin;
  logic [W:1]   carry_nc;   // carries with a zero carry-in
  logic [W:1]   all_prop;   // every lower bit propagates

  assign hot  = a_nz & b_nz;
  assign ovf0 = carry_nc[W];
  assign cin  = hot & ~ovf0;
  assign carry[0] = cin;

  for (genvar i = 1; i <= W; i++) begin : g_carry
    localparam logic [W:0] LOW_I = (UNIT << i) - UNIT;
    logic [i-1:0] terms;

    for (genvar j = 0; j < i; j++) begin : g_term
      localparam logic [W:0]   LOW_J = (UNIT << (j + 1)) - UNIT;
      localparam logic [W-1:0] RUN   = LOW_I[W-1:0] & ~LOW_J[W-1:0];
      assign terms[j] = gen[j] & (&(prop | ~RUN));
    end

    assign carry_nc[i] = |terms;
    assign all_prop[i] = &(prop | ~LOW_I[W-1:0]);
    assign carry[i]    = carry_nc[i] | (all_prop[i] & cin);
  end

endmodule

// File: rtl/mod2n1_resolve.sv
// Sum bits and the result non-zero flag.
module mod2n1_resolve #(
  parameter int W = 16
) (
  input  logic [W-1:0] prop,
  input  logic [W:0]   carry,
  input  logic         ovf0,
  input  logic         a_nz,
  input  logic         b_nz,
  output logic [W-1:0] res_val,
  output logic         res_nz
);

  assign res_val = prop ^ carry[W-1:0];
  assign res_nz  = (ovf0 | ~carry[W]) & (a_nz | b_nz);

endmodule

// File: rtl/mod2n1_outreg.sv
// Output register stage used in registered mode.
module mod2n1_outreg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_val,
  input  logic         d_nz,
  output logic [W-1:0] q_val,
  output logic         q_nz
);

  logic [W-1:0] val_d, val_q;
  logic         nz_d,  nz_q;

  always_comb begin
    val_d = d_val;
    nz_d  = d_nz;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q <= '0;
      nz_q  <= 1'b0;
    end else begin
      val_q <= val_d;
      nz_q  <= nz_d;
    end
  end

  assign q_val = val_q;
  assign q_nz  = nz_q;

  AST_REG_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (q_val == $past(d_val) && q_nz == $past(d_nz)))
    else $error("output register latency broken"); // R8

endmodule

// File: rtl/mod2n1_cla_adder.sv
module mod2n1_cla_adder #(
  parameter int                     W        = 16,
  parameter mod2n1_pkg::out_mode_e  OUT_MODE = mod2n1_pkg::OUT_REG
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a_val,
  input  logic         a_nz,
  input  logic [W-1:0] b_val,
  input  logic         b_nz,
  output logic [W-1:0] sum_val,
  output logic         sum_nz
);

  localparam logic [W:0]   UNIT_X = {{W{1'b0}}, 1'b1};
  localparam logic [W:0]   WRAP   = (UNIT_X << W) - UNIT_X;
  localparam logic [W-1:0] ONE_W  = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] gen, prop;
  logic [W:0]   carry;
  logic         ovf0;
  logic [W-1:0] res_val;
  logic         res_nz;

  mod2n1_pg #(.W(W)) u_pg (
    .a    (a_val),
    .b    (b_val),
    .gen  (gen),
    .prop (prop)
  );

  mod2n1_lookahead #(.W(W)) u_cla (
    .gen   (gen),
    .prop  (prop),
    .a_nz  (a_nz),
    .b_nz  (b_nz),
    .ovf0  (ovf0),
    .carry (carry)
  );

  mod2n1_resolve #(.W(W)) u_res (
    .prop    (prop),
    .carry   (carry),
    .ovf0    (ovf0),
    .a_nz    (a_nz),
    .b_nz    (b_nz),
    .res_val (res_val),
    .res_nz  (res_nz)
  );

  if (OUT_MODE == mod2n1_pkg::OUT_REG) begin : g_reg
    mod2n1_outreg #(.W(W)) u_out (
      .clk   (clk),
      .rst_n (rst_n),
      .d_val (res_val),
      .d_nz  (res_nz),
      .q_val (sum_val),
      .q_nz  (sum_nz)
    );
  end else begin : g_comb
    assign sum_val = res_val;
    assign sum_nz  = res_nz;
  end

  // Width-extended operand sum, used only by the checks below.
  logic [W:0] op_sum;
  assign op_sum = {1'b0, a_val} + {1'b0, b_val};

  AST_OPERAND_FORM: assert property (@(posedge clk) disable iff (!rst_n)
    (!a_nz |-> a_val == '0) and (!b_nz |-> b_val == '0))
    else $error("zero operand carries a non-zero field"); // R1

  AST_ZERO_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    !res_nz |-> res_val == '0)
    else $error("zero result with non-zero field"); // R3

  AST_ZERO_OPERAND: assert property (@(posedge clk) disable iff (!rst_n)
    !b_nz |-> (res_val == a_val && res_nz == a_nz))
    else $error("zero operand changed the other operand"); // R4

  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (a_nz && b_nz && op_sum == WRAP) |-> (!res_nz && res_val == '0))
    else $error("exact modulus did not wrap to zero"); // R5

  AST_OVF_FOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (a_nz && b_nz && op_sum[W]) |-> (res_nz && res_val == op_sum[W-1:0]))
    else $error("overflow fold wrong"); // R6

  AST_NO_OVF_BUMP: assert property (@(posedge clk) disable iff (!rst_n)
    (a_nz && b_nz && op_sum < WRAP) |-> (res_nz && res_val == op_sum[W-1:0] + ONE_W))
    else $error("hot carry-in missing"); // R7

endmodule

// File: tb/tb_mod2n1_cla_adder.sv
module tb_mod2n1_cla_adder;

  localparam int WB = 16;
  localparam int WS = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;

  logic [WB-1:0] a_val, b_val, sum_val;
  logic          a_nz, b_nz, sum_nz;
  logic [WS-1:0] sa_val, sb_val, ssum_val;
  logic          sa_nz, sb_nz, ssum_nz;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;
  int prev_v = 0;
  int prev_n = 0;

  always #2ns clk = ~clk;   // 250 MHz

  mod2n1_cla_adder #(.W(WB), .OUT_MODE(mod2n1_pkg::OUT_REG)) dut (
    .clk(clk), .rst_n(rst_n),
    .a_val(a_val), .a_nz(a_nz), .b_val(b_val), .b_nz(b_nz),
    .sum_val(sum_val), .sum_nz(sum_nz)
  );

  mod2n1_cla_adder #(.W(WS), .OUT_MODE(mod2n1_pkg::OUT_COMB)) dut_small (
    .clk(clk), .rst_n(rst_n),
    .a_val(sa_val), .a_nz(sa_nz), .b_val(sb_val), .b_nz(sb_nz),
    .sum_val(ssum_val), .sum_nz(ssum_nz)
  );

  // Reference from R1/R2: decode, add as integers, reduce, re-encode.
  function automatic void ref_add(input int w, input int av, input int an,
                                  input int bv, input int bn,
                                  output int sv, output int sn);
    int m = (1 << w) + 1;
    int va = an ? av + 1 : 0;
    int vb = bn ? bv + 1 : 0;
    int s  = (va + vb) % m;
    sn = (s != 0) ? 1 : 0;
    sv = (s != 0) ? s - 1 : 0;
  endfunction

  function automatic string case_tag(input int w, input int av, input int an,
                                     input int bv, input int bn);
    int full = 1 << w;
    if (an == 0 || bn == 0) return "R4";
    if (av + bv == full - 1) return "R5";
    if (av + bv >= full) return "R6";
    return "R7";
  endfunction

  task automatic check(input string tag, input int got_v, input int got_n,
                       input int exp_v, input int exp_n);
    n_checks++;
    if (got_v != exp_v || got_n != exp_n) begin
      n_fail++;
      $display("FAIL %s (R2): got field=%0d flag=%0d, expected field=%0d flag=%0d",
               tag, got_v, got_n, exp_v, exp_n);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  endtask

  // Registered path: called at a falling edge; checks hold, then the new result.
  task automatic apply_reg(input int av, input int an, input int bv, input int bn);
    int ev, en;
    a_val = WB'(av); a_nz = an[0]; b_val = WB'(bv); b_nz = bn[0];
    #1ns;
    check("R8 hold", int'(sum_val), int'(sum_nz), prev_v, prev_n);
    @(negedge clk);
    ref_add(WB, av, an, bv, bn, ev, en);
    check(case_tag(WB, av, an, bv, bn), int'(sum_val), int'(sum_nz), ev, en);
    prev_v = ev;
    prev_n = en;
  endtask

  // Builds a well-formed operand (R1) from an integer value 0..2^w.
  task automatic reg_value(input int va, input int vb);
    apply_reg(va ? va - 1 : 0, va ? 1 : 0, vb ? vb - 1 : 0, vb ? 1 : 0);
  endtask

  initial begin
    #(4ns * 200000);
    n_fail++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    int full = 1 << WB;
    void'($urandom(32'h1357_2468));
    a_val = 16'd5; a_nz = 1'b1; b_val = 16'd9; b_nz = 1'b1;
    sa_val = '0; sa_nz = 1'b0; sb_val = '0; sb_nz = 1'b0;

    // R9: outputs cleared while reset is held, despite live inputs.
    repeat (3) @(negedge clk);
    check("R9", int'(sum_val), int'(sum_nz), 0, 0);
    rst_n = 1'b1;
    a_val = '0; a_nz = 1'b0; b_val = '0; b_nz = 1'b0;
    @(negedge clk);
    check("R9 post", int'(sum_val), int'(sum_nz), 0, 0);
    prev_v = 0; prev_n = 0;

    // Directed corners on the wide registered instance.
    reg_value(0, 0);                 // R4 both zero
    reg_value(1234, 0);              // R4
    reg_value(0, full);              // R4 largest value
    reg_value(1, full);              // R5 sums to modulus
    reg_value(full, full);           // R6 largest pair
    reg_value(full, 2);              // R6
    reg_value(1, 1);                 // R7 smallest pair
    reg_value(40000, 25537);         // R5
    reg_value(40000, 25536);         // R7 one below wrap
    reg_value(40000, 25538);         // R6 one above wrap

    // Constrained random with biased corners.
    for (int k = 0; k < 3000; k++) begin
      int sel = $urandom % 8;
      int av = $urandom % full;
      int bv = $urandom % full;
      int an = 1, bn = 1;
      case (sel)
        0: begin av = 0; an = 0; end
        1: begin bv = 0; bn = 0; end
        2: bv = full - 1 - av;
        3: begin av = full - 1; bv = $urandom % 4; end
        default: ;
      endcase
      apply_reg(av, an, bv, bn);
    end

    // Exhaustive narrow combinational instance; R8 comb path, R3 zero field.
    for (int va = 0; va <= (1 << WS); va++) begin
      for (int vb = 0; vb <= (1 << WS); vb++) begin
        int ev, en, av, an, bv, bn;
        av = va ? va - 1 : 0; an = va ? 1 : 0;
        bv = vb ? vb - 1 : 0; bn = vb ? 1 : 0;
        sa_val = WS'(av); sa_nz = an[0]; sb_val = WS'(bv); sb_nz = bn[0];
        #1ns;
        ref_add(WS, av, an, bv, bn, ev, en);
        check(case_tag(WS, av, an, bv, bn), int'(ssum_val), int'(ssum_nz), ev, en);
        if (en == 0) check("R3", int'(ssum_val), int'(ssum_nz), 0, 0);
      end
    end

    finish_run();
  end

endmodule